// File: doc/BRIEF.md
# Upset Checker with Burst Counter

This block sits on the tester side of a shift-chain upset experiment. The chain under test moves one bit per fast clock. Every fourth clock the chain's last four bits arrive as a capture window, marked by a one-cycle strobe. On every strobe the checker rebuilds the window it should have received for the selected data pattern and compares the two, with no sampling gaps. The pattern can be all zeros, all ones or alternating bits.

Each miscompare adds to a saturating error total. Each one is tagged with the value of a free-running cycle timestamp and is offered to a downstream consumer as a record. The record holds the timestamp, the observed window, the expected window and a burst flag. A miscompare on a capture that directly follows another miscompared capture counts as a burst, so isolated upsets can be told apart from multi-cycle events. A record that cannot be handed over because the consumer is stalled is lost, and a sticky overflow flag is set. A clear input restarts the counters, the timestamp and the burst history without disturbing the chosen pattern.

Top module: `upset_monitor`

## Requirements
- R1: After reset, err_count, burst_count, rec_valid and overflow are 0, and the first record taken after reset carries a stamp equal to the number of rising edges between reset release and its capture edge.
- R2: mode 2'b00 expects window 4'b0000 and mode 2'b01 expects 4'b1111; any capture whose cap_data differs from the expected window is a fault.
- R3: With mode[1]=1 (alternating pattern) the expected window is fixed by the first capture taken in that mode after reset: 4'b0101 if cap_data differs from 4'b0101 in at most 2 bits, otherwise 4'b1010. It is then kept for every later capture, including the first one, until the next reset.
- R4: Every fault capture raises err_count by one. Captures that match and cycles without cap_valid leave it unchanged.
- R5: err_count and burst_count stop at their all-ones value (2**CNT_W-1) and do not wrap.
- R6: A fault on a capture whose previous capture was also a fault raises burst_count by one and sets rec_burst in its record. Idle cycles between the two captures do not break the run.
- R7: rec_stamp is the timestamp value in the cycle of the faulty capture. The timestamp starts at 0 and rises by one every clock.
- R8: A record is offered with rec_valid=1 and its fields stay unchanged until a cycle with rec_ready=1. A new fault in that same cycle loads the next record directly.
- R9: A fault while a record is pending and rec_ready=0 is dropped, and overflow is set and held until clear or reset.
- R10: clear=1 zeroes err_count, burst_count, overflow, the burst history and the timestamp. A capture in the same cycle is ignored. The mode and the alignment chosen for the alternating pattern are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast test clock |
| rst_n | input | 1 | Active-low reset |
| clear | input | 1 | Restart counters, timestamp, overflow and burst history |
| mode | input | 2 | 00 zeros, 01 ones, 1x alternating |
| cap_valid | input | 1 | Capture strobe, one cycle per window |
| cap_data | input | 4 | Captured window |
| rec_ready | input | 1 | Consumer accepts the pending record |
| err_count | output | CNT_W | Saturating fault total |
| burst_count | output | CNT_W | Saturating burst total |
| rec_valid | output | 1 | Record pending |
| rec_stamp | output | TS_W | Timestamp of the recorded fault |
| rec_seen | output | 4 | Observed window |
| rec_want | output | 4 | Expected window |
| rec_burst | output | 1 | Fault continued a run of faults |
| overflow | output | 1 | Sticky: a record was dropped |

## Verification
Two clashes are provoked on purpose. In the first, a faulty capture arrives in the same cycle as clear. The capture must leave no trace: counters stay at zero, no record appears and the burst history stays empty, so a fault on the next capture is not a burst. In the second, a fault arrives while a record is pending. This is driven once with rec_ready high, where the new record must replace the old one, and once with it low, where the fault still counts but is dropped and overflow rises. A bench model built from the requirements judges both cases at every step.

// File: rtl/upset_monitor.sv
module upset_monitor #(
  parameter int CNT_W = 16,
  parameter int TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [1:0]       mode,
  input  logic             cap_valid,
  input  logic [3:0]       cap_data,
  input  logic             rec_ready,
  output logic [CNT_W-1:0] err_count,
  output logic [CNT_W-1:0] burst_count,
  output logic             rec_valid,
  output logic [TS_W-1:0]  rec_stamp,
  output logic [3:0]       rec_seen,
  output logic [3:0]       rec_want,
  output logic             rec_burst,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [3:0] ALT_A = 4'b0101;
  localparam logic [3:0] ALT_B = 4'b1010;

  logic [TS_W-1:0] ts;
  logic            aligned;
  logic [3:0]      alt_word;
  logic            prev_fault;

  wire [3:0] diff_a = cap_data ^ ALT_A;
  wire [2:0] dist_a = {2'b0, diff_a[0]} + {2'b0, diff_a[1]} + {2'b0, diff_a[2]} + {2'b0, diff_a[3]};
  wire [3:0] alt_first = (dist_a <= 3'd2) ? ALT_A : ALT_B;
  wire [3:0] alt_now   = aligned ? alt_word : alt_first;
  wire [3:0] expect_w  = mode[1] ? alt_now : {4{mode[0]}};

  wire take      = cap_valid && !clear;
  wire fault     = take && (cap_data != expect_w);
  wire slot_free = !rec_valid || rec_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts <= '0;
    else if (clear) ts <= '0;
    else ts <= ts + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aligned  <= 1'b0;
      alt_word <= ALT_A;
    end else if (take && mode[1] && !aligned) begin
      aligned  <= 1'b1;
      alt_word <= alt_first;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_count   <= '0;
      burst_count <= '0;
      prev_fault  <= 1'b0;
      overflow    <= 1'b0;
    end else if (clear) begin
      err_count   <= '0;
      burst_count <= '0;
      prev_fault  <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      if (take) prev_fault <= fault;
      if (fault && err_count != CNT_MAX) err_count <= err_count + 1'b1;
      if (fault && prev_fault && burst_count != CNT_MAX) burst_count <= burst_count + 1'b1;
      if (fault && !slot_free) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_stamp <= '0;
      rec_seen  <= '0;
      rec_want  <= '0;
      rec_burst <= 1'b0;
    end else if (fault && slot_free) begin
      rec_valid <= 1'b1;
      rec_stamp <= ts;
      rec_seen  <= cap_data;
      rec_want  <= expect_w;
      rec_burst <= prev_fault;
    end else if (rec_ready) begin
      rec_valid <= 1'b0;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_stamp) && $stable(rec_seen)
                                   && $stable(rec_want) && $stable(rec_burst)));

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !cap_valid) |=> $stable(err_count) && $stable(burst_count));

  p_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && err_count == CNT_MAX) |=> err_count == CNT_MAX);

  p_burst_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_count <= err_count);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clear) |=> overflow);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (err_count == '0 && burst_count == '0 && !overflow));

  p_record_mismatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_seen != rec_want);
endmodule

// File: tb/tb_upset_monitor.sv
module tb_upset_monitor;
  localparam int CW = 4;
  localparam int TW = 32;
  localparam logic [CW-1:0] MAXC = '1;

  logic clk = 0, rst_n = 0, clear = 0, cap_valid = 0, rec_ready = 0;
  logic [1:0] mode = 0;
  logic [3:0] cap_data = 0;
  logic [CW-1:0] err_count, burst_count;
  logic rec_valid, rec_burst, overflow;
  logic [TW-1:0] rec_stamp;
  logic [3:0] rec_seen, rec_want;

  upset_monitor #(.CNT_W(CW), .TS_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .mode(mode), .cap_valid(cap_valid),
    .cap_data(cap_data), .rec_ready(rec_ready), .err_count(err_count),
    .burst_count(burst_count), .rec_valid(rec_valid), .rec_stamp(rec_stamp),
    .rec_seen(rec_seen), .rec_want(rec_want), .rec_burst(rec_burst), .overflow(overflow));

  always #4 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  logic [CW-1:0] m_err, m_burst;
  logic m_prev, m_ov, m_al, m_rv, m_rb;
  logic [3:0] m_alt, m_ro, m_re;
  logic [TW-1:0] m_ts, m_rs;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " R4 err_count"}, 64'(err_count), 64'(m_err));
    chk({tag, " R6 burst_count"}, 64'(burst_count), 64'(m_burst));
    chk({tag, " R9 overflow"}, 64'(overflow), 64'(m_ov));
    chk({tag, " R8 rec_valid"}, 64'(rec_valid), 64'(m_rv));
    if (m_rv) begin
      chk({tag, " R7 rec_stamp"}, 64'(rec_stamp), 64'(m_rs));
      chk({tag, " R2 rec_seen"}, 64'(rec_seen), 64'(m_ro));
      chk({tag, " R3 rec_want"}, 64'(rec_want), 64'(m_re));
      chk({tag, " R6 rec_burst"}, 64'(rec_burst), 64'(m_rb));
    end
  endtask

  task automatic model_reset();
    m_err = 0; m_burst = 0; m_prev = 0; m_ov = 0; m_al = 0; m_rv = 0; m_rb = 0;
    m_alt = 4'b0101; m_ro = 0; m_re = 0; m_ts = 0; m_rs = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cap_valid = 0; clear = 0; rec_ready = 0;
    @(negedge clk);
    model_reset();
    rst_n = 1;
  endtask

  task automatic step(input logic v, input logic [3:0] d, input logic clr, input logic rdy,
                      input string tag);
    logic [3:0] e;
    logic f, free;
    int ones;
    cap_valid = v; cap_data = d; clear = clr; rec_ready = rdy;
    @(posedge clk);
    free = !m_rv || rdy;
    if (m_rv && rdy) m_rv = 0;
    if (clr) begin
      m_err = 0; m_burst = 0; m_prev = 0; m_ov = 0; m_ts = 0;
    end else begin
      if (v) begin
        if (!mode[1]) e = {4{mode[0]}};
        else begin
          if (!m_al) begin
            ones = 0;
            for (int b = 0; b < 4; b++) ones += int'(d[b] ^ (b % 2 == 0));
            m_alt = (ones <= 2) ? 4'b0101 : 4'b1010;
            m_al = 1;
          end
          e = m_alt;
        end
        f = (d != e);
        if (f) begin
          if (m_err != MAXC) m_err++;
          if (m_prev && m_burst != MAXC) m_burst++;
          if (free) begin
            m_rv = 1; m_rs = m_ts; m_ro = d; m_re = e; m_rb = m_prev;
          end else m_ov = 1;
        end
        m_prev = f;
      end
      m_ts++;
    end
    @(negedge clk);
    compare(tag);
    cap_valid = 0; clear = 0;
  endtask

  initial begin
    model_reset();
    do_reset();
    @(negedge clk);
    m_ts = 1;
    chk("R1 err_count after reset", 64'(err_count), 0);
    chk("R1 burst_count after reset", 64'(burst_count), 0);
    chk("R1 rec_valid after reset", 64'(rec_valid), 0);
    chk("R1 overflow after reset", 64'(overflow), 0);
    step(1, 4'hF, 0, 1, "R1 first stamp");

    mode = 2'b00;
    for (int i = 0; i < 16; i++) begin
      step(1, 4'(i), 0, 1, "R2 zeros sweep");
      step(0, 0, 0, i[0], "R2 zeros idle");
    end
    mode = 2'b01;
    for (int i = 0; i < 16; i++) begin
      step(1, 4'(i), 0, i[1], "R2 ones sweep");
      step(0, 0, 0, 1, "R8 ones drain");
    end

    step(0, 0, 1, 1, "R10 clear");
    for (int s = 0; s < 2; s++) begin
      do_reset();
      mode = 2'b10;
      step(1, s == 0 ? 4'b1010 : 4'b0111, 0, 1, "R3 first alternating");
      for (int i = 0; i < 16; i++) step(1, 4'(i), 0, 1, "R3 alternating sweep");
      step(1, 4'b1110, 1, 1, "R10 clear keeps alignment");
      step(1, 4'b1010, 0, 1, "R3 after clear");
      step(1, 4'b0101, 0, 1, "R3 after clear b");
    end

    mode = 2'b00;
    for (int i = 0; i < 20; i++) step(1, 4'b1000, 0, 1, "R5 saturate run");
    step(0, 0, 0, 1, "R5 idle");
    step(0, 0, 1, 1, "R10 clear counters");
    step(1, 4'b0001, 0, 1, "R6 isolated");
    step(0, 0, 0, 1, "R6 gap");
    step(0, 0, 0, 1, "R6 gap2");
    step(1, 4'b0010, 0, 1, "R6 run over gap");
    step(1, 4'b0000, 0, 1, "R6 good breaks run");
    step(1, 4'b0100, 0, 1, "R6 new isolated");

    step(0, 0, 0, 1, "R9 drain");
    step(1, 4'b0011, 0, 0, "R9 load pending");
    step(1, 4'b0110, 0, 0, "R9 dropped");
    step(0, 0, 0, 0, "R8 still pending");
    step(1, 4'b1100, 0, 1, "R8 replace on ready");
    step(0, 0, 0, 1, "R8 drain");

    step(1, 4'b1111, 1, 1, "R10 capture with clear");
    step(1, 4'b0001, 0, 1, "R10 no burst after clear");
    step(0, 0, 0, 1, "R10 idle");

    mode = 2'b01;
    for (int i = 0; i < 40; i++) step(i % 3 != 2, 4'(i * 5), i % 7 == 0, i % 4 != 0, "R4 mixed");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule